// File: doc/BRIEF.md
# Display Frame-Lock Mutex Controller

This block arbitrates reprogramming of a display pipeline. It holds ten independent lock slots. Each slot owns a 64-bit membership mask of pipeline modules and a frame-start source selector. Software enables a slot, requests its lock, and polls until the grant bit reads 1. It then reprograms the member modules and releases the lock. On release the slot schedules a one-cycle burst of update strobes, one per member module, so that every member applies its new settings on the same frame boundary.

A slot can be tied to one of six frame-start pulse inputs, or left in free-running mode with no frame source. In free-running mode both the grant and the strobe burst follow one clock cycle after the triggering register write. With a source selected, both wait for the next pulse on that input. All access goes through a single-cycle 32-bit word write port and a combinational read port. Slot n owns the six words at byte offsets 0x20 + 0x20·n + {0x00, 0x04, 0x08, 0x0C, 0x10, 0x14}.

Top module: `dmx_ctrl`

## Requirements
- R1: After reset, every slot reads zero in all its words, and all 640 update strobe outputs are low.
- R2: Slot n, for n = 0..9, decodes its words at 0x20+0x20n+sub. sub 0x00 is run control (bit 0). sub 0x04 is the lock word: write bit 0 = request, read bit 0 = request and bit 1 = grant. sub 0x08 is the reset word. sub 0x0C is mask bits 31:0. sub 0x10 is the source select (3 bits, upper bits read zero). sub 0x14 is mask bits 63:32. The mask words and the select read back what was written.
- R3: Reads from any offset outside these groups return zero, and writes to such offsets change no slot's state.
- R4: In free-running mode (select 0), an enabled slot's grant bit reads 1 starting one clock edge after the edge that captured the request write.
- R5: With select code c in 1..6, the grant is set on the edge that samples frame-start input bit c−1 high while the slot is enabled and requesting. Pulses on other inputs have no effect.
- R6: A slot whose run-control bit is 0 never grants its lock, whether a request or a frame-start pulse arrives.
- R7: Writing 0 to the lock word of a granted slot clears the grant and, for exactly one cycle, drives that slot's strobe lane (upd_strobe[64n+63:64n]) to the mask value. This happens one edge after the release in free-running mode, or on the edge that samples the selected pulse otherwise.
- R8: No strobes are issued while a slot is requesting. A burst pending from a release stays deferred while a new request is held. A request withdrawn before it is granted produces no strobes.
- R9: Writing 1 to bit 0 of the reset word clears the slot's run control, its grant and any pending burst. The mask and select words are kept.
- R10: Each slot drives only its own strobe lane; other lanes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 9 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sof_in | input | 6 | Frame-start pulses; bit c−1 serves select code c |
| upd_strobe | output | 640 | Update strobes, 64 per slot, slot n at bits 64n+63:64n |

## Verification
A table of six slot setups exercises the full grant-and-release path. The entries cover free-running mode and four different frame-start codes, and masks with only the lowest bit, bits across the 31/32 boundary, only the upper word, and dense patterns. Each entry therefore separates a wrong lane, a swapped half-word or a wrong source index from the correct result. In each frame-start entry a pulse on a wrong input comes first and must leave the grant clear, and the strobe lane must stay low until the chosen pulse arrives. This distinguishes source selection from any-pulse behaviour. Directed sequences cover a re-request during a pending burst, a withdrawn request, a disabled slot, the reset word with and without a pending burst, and unmapped accesses.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
    localparam int NUM_INST = 10;
    localparam int DATA_W   = 32;
    localparam int MASK_W   = 2 * DATA_W;
    localparam int SOF_SRC  = 6;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 9;
    localparam int GRP_LSB  = 5;
    localparam int IDX_W    = $clog2(NUM_INST);

    typedef enum logic [2:0] {
        FLD_EN   = 3'd0,
        FLD_LOCK = 3'd1,
        FLD_RST  = 3'd2,
        FLD_MLO  = 3'd3,
        FLD_SOF  = 3'd4,
        FLD_MHI  = 3'd5,
        FLD_NONE = 3'd7
    } fld_e;

    typedef struct packed {
        logic              en;
        logic              req;
        logic              grant;
        logic              pend;
        logic [SEL_W-1:0]  sel;
        logic [MASK_W-1:0] mask;
        logic [MASK_W-1:0] strobe;
    } slot_t;
endpackage

// File: rtl/dmx_decode.sv
`timescale 1ns/1ps
module dmx_decode
    import dmx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output fld_e              fld
);
    localparam int GRP_W = ADDR_W - GRP_LSB;

    logic [GRP_W-1:0] grp;
    logic [2:0]       word;

    always_comb begin
        grp  = addr[ADDR_W-1:GRP_LSB];
        word = addr[GRP_LSB-1:2];
        hit  = 1'b0;
        idx  = '0;
        fld  = FLD_NONE;
        if (addr[1:0] == 2'b00 && grp >= GRP_W'(1) && grp <= GRP_W'(NUM_INST)) begin
            idx = IDX_W'(grp - GRP_W'(1));
            case (word)
                3'd0:    fld = FLD_EN;
                3'd1:    fld = FLD_LOCK;
                3'd2:    fld = FLD_RST;
                3'd3:    fld = FLD_MLO;
                3'd4:    fld = FLD_SOF;
                3'd5:    fld = FLD_MHI;
                default: fld = FLD_NONE;
            endcase
            hit = (fld != FLD_NONE);
        end
    end
endmodule

// File: rtl/dmx_sof_pick.sv
`timescale 1ns/1ps
module dmx_sof_pick
    import dmx_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [SOF_SRC-1:0] sof_in,
    output logic               single,
    output logic               hit
);
    always_comb begin
        single = (sel == '0);
        hit    = 1'b0;
        for (int s = 0; s < SOF_SRC; s++) begin
            if (sel == SEL_W'(s + 1)) hit = sof_in[s];
        end
    end
endmodule

// File: rtl/dmx_slot.sv
`timescale 1ns/1ps
module dmx_slot
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fld_e              fld,
    input  logic [DATA_W-1:0] wdata,
    input  logic              single,
    input  logic              hit,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              req,
    output logic              grant,
    output logic              pend,
    output logic [MASK_W-1:0] strobe
);
    slot_t st_q, st_d;
    logic  evt;

    // Trigger event: every cycle in free-running mode, else the chosen pulse.
    assign evt = single | hit;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = '0;

        if (st_q.en && st_q.req && !st_q.grant && evt) st_d.grant = 1'b1;

        // Deferred burst fires only once nobody is requesting the slot.
        if (st_q.pend && !st_q.req && evt) begin
            st_d.strobe = st_q.mask;
            st_d.pend   = 1'b0;
        end

        if (wr_en) begin
            case (fld)
                FLD_EN:   st_d.en = wdata[0];
                FLD_LOCK: begin
                    st_d.req = wdata[0];
                    if (!wdata[0]) begin
                        if (st_q.grant) st_d.pend = 1'b1;
                        st_d.grant = 1'b0;
                    end
                end
                FLD_RST:  if (wdata[0]) begin
                    st_d.en    = 1'b0;
                    st_d.grant = 1'b0;
                    st_d.pend  = 1'b0;
                end
                FLD_MLO:  st_d.mask[DATA_W-1:0]      = wdata;
                FLD_MHI:  st_d.mask[MASK_W-1:DATA_W] = wdata;
                FLD_SOF:  st_d.sel = wdata[SEL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (fld)
            FLD_EN:   rdata = {{(DATA_W-1){1'b0}}, st_q.en};
            FLD_LOCK: rdata = {{(DATA_W-2){1'b0}}, st_q.grant, st_q.req};
            FLD_MLO:  rdata = st_q.mask[DATA_W-1:0];
            FLD_MHI:  rdata = st_q.mask[MASK_W-1:DATA_W];
            FLD_SOF:  rdata = {{(DATA_W-SEL_W){1'b0}}, st_q.sel};
            default:  rdata = '0;
        endcase
    end

    assign sel    = st_q.sel;
    assign en     = st_q.en;
    assign req    = st_q.req;
    assign grant  = st_q.grant;
    assign pend   = st_q.pend;
    assign strobe = st_q.strobe;
endmodule

// File: rtl/dmx_ctrl.sv
`timescale 1ns/1ps
module dmx_ctrl
    import dmx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [SOF_SRC-1:0]         sof_in,
    output logic [NUM_INST*MASK_W-1:0] upd_strobe
);
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    fld_e              dec_fld;
    logic [DATA_W-1:0] slot_rd [NUM_INST];
    logic [NUM_INST-1:0] en_vec, req_vec, grant_vec, pend_vec;

    dmx_decode u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .fld  (dec_fld)
    );

    for (genvar i = 0; i < NUM_INST; i++) begin : g_slot
        logic [SEL_W-1:0] sel;
        logic             single;
        logic             hit;
        logic             wr_here;

        assign wr_here = bus_wr && dec_hit && (dec_idx == IDX_W'(i));

        dmx_sof_pick u_pick (
            .sel    (sel),
            .sof_in (sof_in),
            .single (single),
            .hit    (hit)
        );

        dmx_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_here),
            .fld    (dec_fld),
            .wdata  (bus_wdata),
            .single (single),
            .hit    (hit),
            .sel    (sel),
            .rdata  (slot_rd[i]),
            .en     (en_vec[i]),
            .req    (req_vec[i]),
            .grant  (grant_vec[i]),
            .pend   (pend_vec[i]),
            .strobe (upd_strobe[i*MASK_W +: MASK_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (dec_hit && dec_idx == IDX_W'(i)) bus_rdata = slot_rd[i];
        end
    end
endmodule

// File: rtl/dmx_ctrl_chk.sv
`timescale 1ns/1ps
module dmx_ctrl_chk
    import dmx_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_INST-1:0]        en_vec,
    input logic [NUM_INST-1:0]        req_vec,
    input logic [NUM_INST-1:0]        grant_vec,
    input logic [NUM_INST-1:0]        pend_vec,
    input logic [NUM_INST*MASK_W-1:0] upd_strobe
);
    // Offsets below the first group never decode.
    assert_low_offsets_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(32)) |-> (bus_rdata == '0));

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        logic [MASK_W-1:0] lane;
        assign lane = upd_strobe[i*MASK_W +: MASK_W];

        assert_grant_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_vec[i]) |-> $past(en_vec[i]));

        assert_strobe_from_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (lane != '0) |-> $past(pend_vec[i]));

        assert_strobe_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (lane != '0) |=> (lane == '0));

        assert_no_strobe_while_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lane != '0) |-> $past(!req_vec[i]));

        assert_reset_word_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_wdata[0] && bus_addr == ADDR_W'(32 + 32*i + 8))
            |=> (!en_vec[i] && !grant_vec[i] && !pend_vec[i]));

        assert_select_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(32 + 32*i + 16)) |-> (bus_rdata[DATA_W-1:SEL_W] == '0));
    end
endmodule

bind dmx_ctrl dmx_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .en_vec     (en_vec),
    .req_vec    (req_vec),
    .grant_vec  (grant_vec),
    .pend_vec   (pend_vec),
    .upd_strobe (upd_strobe)
);

// File: tb/dmx_ctrl_test.sv
`timescale 1ns/1ps
module dmx_ctrl_test;
    import dmx_pkg::*;

    localparam int OF_EN = 0, OF_LOCK = 4, OF_RST = 8, OF_MLO = 12, OF_SOF = 16, OF_MHI = 20;
    localparam int NT = 6;
    localparam int          T_INST [NT] = '{0, 3, 9, 5, 7, 2};
    localparam int          T_SEL  [NT] = '{0, 1, 6, 3, 0, 4};
    localparam logic [31:0] T_LO   [NT] = '{32'h0000_0001, 32'h8000_0000, 32'hA5A5_0F0F,
                                            32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    localparam logic [31:0] T_HI   [NT] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0006,
                                            32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000};

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       bus_wr = 1'b0;
    logic [ADDR_W-1:0]          bus_addr = '0;
    logic [DATA_W-1:0]          bus_wdata = '0;
    logic [DATA_W-1:0]          bus_rdata;
    logic [SOF_SRC-1:0]         sof_in = '0;
    logic [NUM_INST*MASK_W-1:0] upd_strobe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmx_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .sof_in     (sof_in),
        .upd_strobe (upd_strobe)
    );

    function automatic logic [ADDR_W-1:0] ra(int inst, int sub);
        return ADDR_W'(32 + 32*inst + sub);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int code);
        @(negedge clk);
        sof_in[code-1] = 1'b1;
        @(negedge clk);
        sof_in = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // All lanes: slot `inst` carries `m`, every other lane must be zero.
    task automatic chk_lanes(input string tag, input int inst, input logic [63:0] m);
        bit ok = 1'b1;
        logic [63:0] act = '0;
        logic [63:0] exp = '0;
        n_chk++;
        for (int j = 0; j < NUM_INST; j++) begin
            logic [63:0] e;
            e = (j == inst) ? m : 64'h0;
            if (ok && upd_strobe[j*MASK_W +: MASK_W] !== e) begin
                ok = 1'b0; act = upd_strobe[j*MASK_W +: MASK_W]; exp = e;
                $display("FAIL %s: lane %0d actual %h expected %h", tag, j, act, exp);
            end
        end
        if (!ok) n_fail++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n; int s; logic [63:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_rd("R1 en", ra(0, OF_EN), 32'h0);
        chk_rd("R1 lock", ra(4, OF_LOCK), 32'h0);
        chk_rd("R1 mlo", ra(9, OF_MLO), 32'h0);
        chk_rd("R1 mhi", ra(9, OF_MHI), 32'h0);
        chk_rd("R1 sof", ra(2, OF_SOF), 32'h0);
        chk_lanes("R1 strobes", 0, 64'h0);

        // R3: unmapped offsets
        wr(9'h038, 32'hFFFF_FFFF);
        wr(9'h004, 32'hFFFF_FFFF);
        wr(9'h160, 32'hFFFF_FFFF);
        chk_rd("R3 low", 9'h004, 32'h0);
        chk_rd("R3 gap", 9'h038, 32'h0);
        chk_rd("R3 past end", 9'h160, 32'h0);
        chk_rd("R3 unaligned", 9'h02D, 32'h0);
        chk_rd("R3 slot0 en kept", ra(0, OF_EN), 32'h0);
        chk_rd("R3 slot0 mask kept", ra(0, OF_MLO), 32'h0);

        // R2: select width
        wr(ra(0, OF_SOF), 32'hFFFF_FFFF);
        chk_rd("R2 sof 3 bits", ra(0, OF_SOF), 32'h7);

        // Table walk: R2, R4, R5, R7, R10
        for (int t = 0; t < NT; t++) begin
            n = T_INST[t]; s = T_SEL[t]; m = {T_HI[t], T_LO[t]};
            wr(ra(n, OF_MLO), T_LO[t]);
            wr(ra(n, OF_MHI), T_HI[t]);
            wr(ra(n, OF_SOF), 32'(s));
            wr(ra(n, OF_EN), 32'h1);
            chk_rd("R2 mlo", ra(n, OF_MLO), T_LO[t]);
            chk_rd("R2 mhi", ra(n, OF_MHI), T_HI[t]);
            chk_rd("R2 sof", ra(n, OF_SOF), 32'(s));
            wr(ra(n, OF_LOCK), 32'h1);
            chk_rd("R4 request only", ra(n, OF_LOCK), 32'h1);
            if (s == 0) begin
                @(negedge clk);
                chk_rd("R4 granted", ra(n, OF_LOCK), 32'h3);
            end else begin
                pulse((s % 6) + 1);
                chk_rd("R5 wrong source", ra(n, OF_LOCK), 32'h1);
                pulse(s);
                chk_rd("R5 granted", ra(n, OF_LOCK), 32'h3);
            end
            wr(ra(n, OF_LOCK), 32'h0);
            chk_rd("R7 grant cleared", ra(n, OF_LOCK), 32'h0);
            chk_lanes("R7 not yet", n, 64'h0);
            if (s == 0) begin
                @(negedge clk);
                chk_lanes("R7 R10 burst", n, m);
            end else begin
                @(negedge clk);
                chk_lanes("R7 waits for pulse", n, 64'h0);
                pulse(s);
                chk_lanes("R7 R10 burst", n, m);
            end
            @(negedge clk);
            chk_lanes("R7 one cycle", n, 64'h0);
        end

        // R8: re-request while burst pending, then withdrawn request
        wr(ra(4, OF_MLO), 32'h0000_00F0);
        wr(ra(4, OF_SOF), 32'h2);
        wr(ra(4, OF_EN), 32'h1);
        wr(ra(4, OF_LOCK), 32'h1);
        pulse(2);
        chk_rd("R8 first grant", ra(4, OF_LOCK), 32'h3);
        wr(ra(4, OF_LOCK), 32'h0);
        wr(ra(4, OF_LOCK), 32'h1);
        pulse(2);
        chk_lanes("R8 held back", 4, 64'h0);
        chk_rd("R8 regranted", ra(4, OF_LOCK), 32'h3);
        wr(ra(4, OF_LOCK), 32'h0);
        pulse(2);
        chk_lanes("R8 burst after release", 4, 64'hF0);
        wr(ra(4, OF_LOCK), 32'h1);
        wr(ra(4, OF_LOCK), 32'h0);
        pulse(2);
        chk_lanes("R8 withdrawn no burst", 4, 64'h0);
        chk_rd("R8 withdrawn no grant", ra(4, OF_LOCK), 32'h0);

        // R6: disabled slot
        wr(ra(1, OF_MLO), 32'h1);
        wr(ra(1, OF_LOCK), 32'h1);
        repeat (3) @(negedge clk);
        chk_rd("R6 free-run no grant", ra(1, OF_LOCK), 32'h1);
        wr(ra(1, OF_SOF), 32'h3);
        pulse(3);
        chk_rd("R6 pulse no grant", ra(1, OF_LOCK), 32'h1);
        chk_lanes("R6 no strobes", 1, 64'h0);

        // R9: reset word while granted
        wr(ra(6, OF_MLO), 32'h55);
        wr(ra(6, OF_MHI), 32'h9);
        wr(ra(6, OF_EN), 32'h1);
        wr(ra(6, OF_LOCK), 32'h1);
        @(negedge clk);
        chk_rd("R9 granted", ra(6, OF_LOCK), 32'h3);
        wr(ra(6, OF_RST), 32'h1);
        chk_rd("R9 en cleared", ra(6, OF_EN), 32'h0);
        chk_rd("R9 grant cleared", ra(6, OF_LOCK), 32'h1);
        chk_rd("R9 mask kept", ra(6, OF_MHI), 32'h9);
        repeat (2) @(negedge clk);
        chk_lanes("R9 no burst", 6, 64'h0);

        // R9: reset word while burst pending
        wr(ra(8, OF_MLO), 32'h3);
        wr(ra(8, OF_SOF), 32'h5);
        wr(ra(8, OF_EN), 32'h1);
        wr(ra(8, OF_LOCK), 32'h1);
        pulse(5);
        wr(ra(8, OF_LOCK), 32'h0);
        wr(ra(8, OF_RST), 32'h1);
        pulse(5);
        chk_lanes("R9 pending dropped", 8, 64'h0);
        chk_rd("R9 select kept", ra(8, OF_SOF), 32'h5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule